// File: doc/BRIEF.md
# Six-Channel High-Side Short-Circuit Blank, Deglitch and Fault Latch

This block guards six high-side output channels against a short to ground. Each channel has a drive request and a comparator input that reports the output node is below its short threshold. When a request goes high, the channel drives and first ignores the comparator for a fixed 40-tick blank window. After that window the comparator must stay asserted for a selectable deglitch time before the block declares a short. A short latches the channel's fault bit and removes its drive enable, even while the request stays high.

Time is counted in 1 µs ticks made from the system clock by a prescaler (`TICK_DIV` clocks per tick). A 2-bit code picks a deglitch of 24, 32, 40 or 48 ticks. Channel 0 reads its own code and channels 1 to 5 read one shared code. A supply-high flag replaces any code with a 10-tick deglitch. One clear input releases every latched fault.

Each channel runs one state machine with four states: `CH_IDLE`, `CH_BLANK`, `CH_WATCH` and `CH_TRIPPED`. These are the transitions:
- *arm*: `CH_IDLE` to `CH_BLANK` when the request rises.
- *unblank*: `CH_BLANK` to `CH_WATCH` when the 40th tick of the window arrives.
- *trip*: `CH_WATCH` to `CH_TRIPPED` when the deglitch count completes.
- *drop*: `CH_BLANK` or `CH_WATCH` to `CH_IDLE` when the request falls.
- *rearm*: `CH_TRIPPED` to `CH_BLANK` on a clear while the request is high.
- *release*: `CH_TRIPPED` to `CH_IDLE` on a clear while the request is low.

Top module: `hs_short_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `drive_en` and `fault` are all zero.
- R2: One clock after `req[i]` rises, `drive_en[i]` is 1. During the blank window that follows, `det[i]` has no effect on `fault[i]`.
- R3: A tick occurs once every `TICK_DIV` clocks. The blank window lasts 40 ticks counted from the request.
- R4: After the blank window ends, `fault[i]` sets only once `det[i]` has been high in every clock across the deglitch number of ticks. Any clock with `det[i]` low restarts the count from zero.
- R5: Deglitch code 0, 1, 2 and 3 give 24, 32, 40 and 48 ticks. Channel 0 uses `dg_sel_ch0` and channels 1 to 5 use `dg_sel_shared`.
- R6: While `supply_high` is 1, the deglitch is 10 ticks whatever the codes say.
- R7: When a short is declared, `fault[i]` becomes 1 and `drive_en[i]` becomes 0 while `req[i]` is still 1. The fault stays set while `clear` is low.
- R8: A clock with `clear` high clears every latched fault. A channel whose request is high then drives again and restarts its 40-tick blank. A clear while no fault is latched has no effect on either output.
- R9: A low `req[i]` turns `drive_en[i]` off on the next clock and discards the blank and deglitch progress. Re-enabling the channel starts a full blank window again.
- R10: When a deglitch completes in the same clock that `clear` is high, the fault is still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_CH | Per-channel drive request |
| det | input | NUM_CH | Per-channel short comparator (1 = node below threshold) |
| dg_sel_ch0 | input | 2 | Deglitch code for channel 0 |
| dg_sel_shared | input | 2 | Deglitch code shared by channels 1 to 5 |
| supply_high | input | 1 | Supply above high threshold; forces the short deglitch |
| clear | input | 1 | Releases all latched faults |
| drive_en | output | NUM_CH | Per-channel drive enable |
| fault | output | NUM_CH | Per-channel latched short fault |

## Verification
The bench holds the comparator high through the whole blank window. A design that did not blank would trip about 40 ticks too early. A one-clock dip in the comparator just before the deglitch completes shows whether the count restarts; a design that only paused the count would trip early. The bench sets different codes on channel 0 and on the shared channels, and it asserts `supply_high` together with the longest code. These cases catch channels that are swapped, codes that are decoded wrongly, and a supply override that is missing. The bench also checks re-enable after a drop, rearm after a clear, a clear held high across a trip, and a clear that arrives with no fault latched. These cases catch counters that carry stale progress, a fault that is lost to a simultaneous clear, and a clear that disturbs a healthy channel.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
    typedef enum logic [1:0] {
        CH_IDLE,
        CH_BLANK,
        CH_WATCH,
        CH_TRIPPED
    } ch_state_t;

    localparam int unsigned DG_SEL_W = 2;
endpackage

// File: rtl/hsg_prescaler.sv
module hsg_prescaler #(
    parameter int unsigned TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pcnt_q;

    assign tick = (pcnt_q == P_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + PW'(1);
        end
    end
endmodule

// File: rtl/hsg_dg_select.sv
module hsg_dg_select
    import hsg_pkg::*;
#(
    parameter int unsigned CNT_W    = 6,
    parameter int unsigned DG_T0    = 24,
    parameter int unsigned DG_T1    = 32,
    parameter int unsigned DG_T2    = 40,
    parameter int unsigned DG_T3    = 48,
    parameter int unsigned DG_FAST  = 10
) (
    input  logic [DG_SEL_W-1:0] sel,
    input  logic                supply_high,
    output logic [CNT_W-1:0]    limit
);
    always_comb begin
        if (supply_high) begin
            limit = CNT_W'(DG_FAST);
        end else begin
            unique case (sel)
                2'd0: limit = CNT_W'(DG_T0);
                2'd1: limit = CNT_W'(DG_T1);
                2'd2: limit = CNT_W'(DG_T2);
                2'd3: limit = CNT_W'(DG_T3);
            endcase
        end
    end
endmodule

// File: rtl/hsg_channel.sv
module hsg_channel
    import hsg_pkg::*;
#(
    parameter int unsigned CNT_W       = 6,
    parameter int unsigned BLANK_TICKS = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             req,
    input  logic             det,
    input  logic             clear,
    input  logic [CNT_W-1:0] dg_limit,
    output logic             drive_en,
    output logic             fault
);
    localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_TICKS - 1);

    ch_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CH_IDLE: begin
                if (req) begin
                    state_d = CH_BLANK;
                    cnt_d   = '0;
                end
            end
            CH_BLANK: begin
                if (!req) begin
                    state_d = CH_IDLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q == BLANK_LAST) begin
                        state_d = CH_WATCH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            CH_WATCH: begin
                if (!req) begin
                    state_d = CH_IDLE;
                    cnt_d   = '0;
                end else if (!det) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q >= dg_limit - CNT_W'(1)) begin
                        state_d = CH_TRIPPED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            CH_TRIPPED: begin
                if (clear) begin
                    state_d = req ? CH_BLANK : CH_IDLE;
                    cnt_d   = '0;
                end
            end
        endcase
    end

    always_comb begin
        drive_en = (state_q == CH_BLANK) || (state_q == CH_WATCH);
        fault    = (state_q == CH_TRIPPED);
    end
endmodule

// File: rtl/hs_short_guard.sv
module hs_short_guard
    import hsg_pkg::*;
#(
    parameter int unsigned NUM_CH      = 6,
    parameter int unsigned TICK_DIV    = 4,
    parameter int unsigned BLANK_TICKS = 40,
    parameter int unsigned DG_T0       = 24,
    parameter int unsigned DG_T1       = 32,
    parameter int unsigned DG_T2       = 40,
    parameter int unsigned DG_T3       = 48,
    parameter int unsigned DG_FAST     = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   req,
    input  logic [NUM_CH-1:0]   det,
    input  logic [1:0]          dg_sel_ch0,
    input  logic [1:0]          dg_sel_shared,
    input  logic                supply_high,
    input  logic                clear,
    output logic [NUM_CH-1:0]   drive_en,
    output logic [NUM_CH-1:0]   fault
);
    localparam int unsigned MAX_A = (BLANK_TICKS > DG_T3) ? BLANK_TICKS : DG_T3;
    localparam int unsigned MAX_B = (DG_T2 > DG_T1) ? DG_T2 : DG_T1;
    localparam int unsigned MAX_C = (DG_T0 > DG_FAST) ? DG_T0 : DG_FAST;
    localparam int unsigned MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned MAX_T = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int unsigned CNT_W = $clog2(MAX_T + 1);

    logic tick;

    hsg_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [DG_SEL_W-1:0] sel;
        logic [CNT_W-1:0]    limit;

        if (ch == 0) begin : g_own
            assign sel = dg_sel_ch0;
        end else begin : g_shared
            assign sel = dg_sel_shared;
        end

        hsg_dg_select #(
            .CNT_W   (CNT_W),
            .DG_T0   (DG_T0),
            .DG_T1   (DG_T1),
            .DG_T2   (DG_T2),
            .DG_T3   (DG_T3),
            .DG_FAST (DG_FAST)
        ) u_sel (
            .sel         (sel),
            .supply_high (supply_high),
            .limit       (limit)
        );

        hsg_channel #(
            .CNT_W       (CNT_W),
            .BLANK_TICKS (BLANK_TICKS)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .req      (req[ch]),
            .det      (det[ch]),
            .clear    (clear),
            .dg_limit (limit),
            .drive_en (drive_en[ch]),
            .fault    (fault[ch])
        );
    end
endmodule

// File: rtl/hsg_checker.sv
module hsg_checker #(
    parameter int unsigned NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] req,
    input logic [NUM_CH-1:0] det,
    input logic              clear,
    input logic [NUM_CH-1:0] drive_en,
    input logic [NUM_CH-1:0] fault
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R7
        fault_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fault[i] && !clear) |=> fault[i]);

        // R7
        fault_cuts_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fault[i] |-> !drive_en[i]);

        // R8
        clear_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fault[i] && clear) |=> !fault[i]);

        // R9
        req_low_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req[i] |=> !drive_en[i]);

        // R4
        trip_needs_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault[i]) |-> $past(det[i]));

        // R2
        arm_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req[i] && !drive_en[i] && !fault[i]) |=> (drive_en[i] || !req[i] || fault[i]) || !$past(req[i]));
    end
endmodule

bind hs_short_guard hsg_checker #(.NUM_CH(NUM_CH)) u_hsg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .det      (det),
    .clear    (clear),
    .drive_en (drive_en),
    .fault    (fault)
);

// File: tb/sim_hs_short_guard.sv
`timescale 1ns/100ps
module sim_hs_short_guard;
    localparam int NCH = 6;
    localparam int DIV = 4;
    localparam int BLANK = 40;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] req = '0;
    logic [NCH-1:0] det = '0;
    logic [1:0]     dg_sel_ch0 = 2'd0;
    logic [1:0]     dg_sel_shared = 2'd0;
    logic           supply_high = 1'b0;
    logic           clear = 1'b0;
    logic [NCH-1:0] drive_en;
    logic [NCH-1:0] fault;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    hs_short_guard #(.NUM_CH(NCH), .TICK_DIV(DIV)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .det           (det),
        .dg_sel_ch0    (dg_sel_ch0),
        .dg_sel_shared (dg_sel_shared),
        .supply_high   (supply_high),
        .clear         (clear),
        .drive_en      (drive_en),
        .fault         (fault)
    );

    // Behavioural reference model: 0 off, 1 blanking, 2 watching, 3 tripped
    int m_st[NCH];
    int m_cnt[NCH];
    int m_pc;

    function automatic int dg_ticks(int code, bit hi);
        if (hi) return 10;
        return 24 + 8 * code;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pc = 0;
            foreach (m_st[k]) begin m_st[k] = 0; m_cnt[k] = 0; end
        end else begin
            bit tk;
            tk = (m_pc == DIV - 1);
            m_pc = tk ? 0 : m_pc + 1;
            for (int k = 0; k < NCH; k++) begin
                int lim;
                lim = dg_ticks((k == 0) ? int'(dg_sel_ch0) : int'(dg_sel_shared), supply_high);
                case (m_st[k])
                    0: if (req[k]) begin m_st[k] = 1; m_cnt[k] = 0; end
                    1: begin
                        if (!req[k]) begin m_st[k] = 0; m_cnt[k] = 0; end
                        else if (tk) begin
                            if (m_cnt[k] == BLANK - 1) begin m_st[k] = 2; m_cnt[k] = 0; end
                            else m_cnt[k]++;
                        end
                    end
                    2: begin
                        if (!req[k]) begin m_st[k] = 0; m_cnt[k] = 0; end
                        else if (!det[k]) m_cnt[k] = 0;
                        else if (tk) begin
                            if (m_cnt[k] >= lim - 1) begin m_st[k] = 3; m_cnt[k] = 0; end
                            else m_cnt[k]++;
                        end
                    end
                    default: if (clear) begin m_st[k] = req[k] ? 1 : 0; m_cnt[k] = 0; end
                endcase
            end
        end
    end

    task automatic check(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [NCH-1:0] e_drv, e_flt;
        for (int k = 0; k < NCH; k++) begin
            e_drv[k] = (m_st[k] == 1) || (m_st[k] == 2);
            e_flt[k] = (m_st[k] == 3);
        end
        check(cur_tag, drive_en, e_drv, "model drive_en");
        check(cur_tag, fault, e_flt, "model fault");
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic quiesce();
        req = '0; det = '0; supply_high = 1'b0;
        dg_sel_ch0 = 2'd0; dg_sel_shared = 2'd0;
        clear = 1'b1; cyc(1); clear = 1'b0; cyc(2);
    endtask

    initial begin : watchdog
        #(150000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        cyc(3);
        check("R1", drive_en, '0, "drive in reset");
        check("R1", fault, '0, "fault in reset");
        rst_n = 1'b1;
        cyc(1);
        check("R1", drive_en | fault, '0, "outputs after reset");

        // R2 R3 R4: blank ignores det, then 24-tick deglitch on ch1
        cur_tag = "R2";
        req[1] = 1'b1; det[1] = 1'b1;
        cyc(1);
        check("R2", drive_en, 6'b000010, "drive one clock after req");
        cyc(199);
        cur_tag = "R3";
        check("R3", fault, '0, "no fault inside blank+deglitch");
        check("R2", drive_en, 6'b000010, "still driving");
        cyc(100);
        cur_tag = "R7";
        check("R4", fault, 6'b000010, "fault after deglitch");
        check("R7", drive_en, '0, "drive removed while req high");
        cyc(50);
        check("R7", fault, 6'b000010, "fault latched");

        // R8: clear rearms a requested channel
        cur_tag = "R8";
        det[1] = 1'b0; clear = 1'b1; cyc(1); clear = 1'b0; cyc(1);
        check("R8", fault, '0, "fault cleared");
        check("R8", drive_en, 6'b000010, "drive back after clear");
        clear = 1'b1; cyc(1); clear = 1'b0; cyc(1);
        check("R8", drive_en, 6'b000010, "clear with no fault keeps drive");
        check("R8", fault, '0, "clear with no fault keeps fault low");
        quiesce();

        // R5: ch0 own code 3 (48 ticks) vs shared code 0 (24 ticks)
        cur_tag = "R5";
        dg_sel_ch0 = 2'd3; dg_sel_shared = 2'd0;
        req[0] = 1'b1; det[0] = 1'b1; req[2] = 1'b1; det[2] = 1'b1;
        cyc(300);
        check("R5", fault, 6'b000100, "shared 24-tick tripped, ch0 not yet");
        cyc(100);
        check("R5", fault, 6'b000101, "ch0 48-tick tripped");
        quiesce();

        // R5: shared code 2 (40 ticks) on ch5
        dg_sel_shared = 2'd2; req[5] = 1'b1; det[5] = 1'b1;
        cyc(310);
        check("R5", fault, '0, "code 2 not tripped early");
        cyc(60);
        check("R5", fault, 6'b100000, "code 2 tripped");
        quiesce();

        // R6: supply_high forces 10 ticks
        cur_tag = "R6";
        supply_high = 1'b1; dg_sel_ch0 = 2'd3; dg_sel_shared = 2'd3;
        req[0] = 1'b1; det[0] = 1'b1; req[3] = 1'b1; det[3] = 1'b1;
        cyc(190);
        check("R6", fault, '0, "not tripped in blank");
        cyc(40);
        check("R6", fault, 6'b001001, "fast deglitch tripped");
        quiesce();

        // R4: a one-clock det dip restarts the deglitch count
        cur_tag = "R4";
        req[4] = 1'b1; det[4] = 1'b1;
        cyc(240);
        det[4] = 1'b0; cyc(1); det[4] = 1'b1;
        cyc(60);
        check("R4", fault, '0, "dip restarted deglitch");
        cyc(140);
        check("R4", fault, 6'b010000, "tripped after full deglitch");
        quiesce();

        // R9: drop and re-enable restarts blank
        cur_tag = "R9";
        req[2] = 1'b1; det[2] = 1'b1;
        cyc(240);
        req[2] = 1'b0; cyc(1);
        check("R9", drive_en, '0, "drop removes drive");
        req[2] = 1'b1;
        cyc(200);
        check("R9", fault, '0, "re-enable restarted blank");
        cyc(100);
        check("R9", fault, 6'b000100, "trip after full blank+deglitch");
        quiesce();

        // R10: clear held high while the deglitch completes
        cur_tag = "R10";
        req[1] = 1'b1; det[1] = 1'b1; clear = 1'b1;
        cyc(300);
        clear = 1'b0; det[1] = 1'b0;
        cyc(5);
        check("R10", drive_en, 6'b000010, "re-armed after a trip that the held clear released");
        quiesce();

        cyc(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule